// File: doc/BRIEF.md
# Manchester Serial Pin Encoder

The block sends a short coded message on one open-drain output pin. Software places a data byte and a two-bit rate code on the inputs, then pulses a Go request. The block sets its Go flag and then its Busy flag. It sends a fixed eight-bit sync pattern followed by the data byte, with each bit Manchester coded into two equal time intervals.

After the last data bit, the block keeps the pin released for an enforced idle period. Only then does it drop Busy and Go. Software therefore needs no timing loops: a cleared Go flag means the block can take the next message.

The pin is never driven high. The block outputs a pull-low enable, and a deasserted enable means the pin is released to high impedance, which the line reads as 1.

Top module: `mgb_encoder`

## Requirements
- R1: While reset is asserted and after it is released, drive_low_o, busy_o and go_o are all 0.
- R2: A go_set_i pulse with go_o low is accepted at that clock edge. go_o reads 1 after that edge while busy_o stays 0 for one more cycle, and busy_o is 1 after the following edge.
- R3: go_set_i is ignored while go_o or busy_o is high. The message in progress continues unchanged, and the new data and rate codes are never sent.
- R4: rate_i codes 0, 1, 2 and 3 give an interval of 1, 2, 4 and 8 clock cycles. The code is captured at acceptance, and later changes to rate_i have no effect.
- R5: The first 16 intervals after Busy rises carry the sync pattern 1111_1110, leftmost bit first.
- R6: The data byte follows the sync pattern with no gap, most significant bit first.
- R7: A 1 bit is sent as released (drive_low_o=0) for one interval, then pulled low (drive_low_o=1) for one interval. A 0 bit is sent as pulled low, then released.
- R8: After the last data bit, the pin stays released for 4 intervals while busy_o and go_o remain 1.
- R9: busy_o and go_o fall on the same edge, right after the idle period. A go_set_i in the very next cycle is accepted.
- R10: When the last data bit is 1, its pulled-low second interval is followed by a release, which gives a closing rising edge on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_set_i | input | 1 | Single-cycle request to start a message |
| data_i | input | 8 | Data byte, captured on acceptance |
| rate_i | input | 2 | Interval select, divide by 2^code |
| busy_o | output | 1 | Message or idle period in progress |
| go_o | output | 1 | Go flag, set on acceptance, cleared after idle |
| drive_low_o | output | 1 | 1 pulls the pin low, 0 releases it |

## Verification
Messages are sent with bytes 5A, A5, 00, FF, 81 and 3C across all four rate codes. All-zero and all-one bytes separate the two half-bit orders. Bytes with an alternating pattern or a 1 in the lowest position expose bit-order errors and check for the closing rising edge. Some messages carry extra Go pulses, new data and changed rate codes, both during the one-cycle arming gap and in the middle of sending, to show that nothing restarts. Messages are sent back to back so the reference model can compare every cycle of the clear-then-accept boundary.

// File: rtl/mgb_pkg.sv
package mgb_pkg;
  localparam int unsigned SYNC_W = 8;
  localparam logic [SYNC_W-1:0] SYNC_PAT = 8'hFE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND,
    ST_HOLD
  } mgb_state_e;
endpackage

// File: rtl/mgb_prescaler.sv
module mgb_prescaler #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int unsigned CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // limit = 2^rate - 1 : low 'rate' bits set
  always_comb begin
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(rate_i));
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && rate_i != '0 && run_i) |=> !tick_o);
endmodule

// File: rtl/mgb_frame_seq.sv
module mgb_frame_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              adv_i,
  input  logic              active_i,
  output logic              drive_low_o,
  output logic              last_o
);
  import mgb_pkg::*;

  localparam int unsigned FRAME_W = SYNC_W + DATA_W;
  localparam int unsigned HALF_N  = 2 * FRAME_W;
  localparam int unsigned HALF_W  = $clog2(HALF_N);

  logic [FRAME_W-1:0] frame_q;
  logic [HALF_W-1:0]  half_q;
  logic               cur_bit;

  assign cur_bit     = frame_q[FRAME_W-1];
  assign last_o      = (half_q == HALF_W'(HALF_N - 1));
  // first half: low for 0; second half: low for 1
  assign drive_low_o = active_i && (half_q[0] ? cur_bit : !cur_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      half_q  <= '0;
    end else if (load_i) begin
      frame_q <= {SYNC_PAT, data_i};
      half_q  <= '0;
    end else if (adv_i) begin
      half_q <= half_q + 1'b1;
      if (half_q[0]) frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
    end
  end

  // R7
  half_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && active_i && !half_q[0]) |=> (drive_low_o != $past(drive_low_o)));
endmodule

// File: rtl/mgb_encoder.sv
module mgb_encoder #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RATE_W    = 2,
  parameter int unsigned IDLE_INTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_set_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              go_o,
  output logic              drive_low_o
);
  import mgb_pkg::*;

  localparam int unsigned IDLE_W = (IDLE_INTS > 1) ? $clog2(IDLE_INTS) : 1;

  mgb_state_e        st_q;
  logic              go_q, busy_q;
  logic [RATE_W-1:0] rate_q;
  logic [IDLE_W-1:0] idle_q;
  logic              tick, last, accept, run, sending;

  assign accept  = go_set_i && (st_q == ST_IDLE);
  assign run     = (st_q == ST_SEND) || (st_q == ST_HOLD);
  assign sending = (st_q == ST_SEND);

  mgb_prescaler #(.RATE_W(RATE_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .rate_i (rate_q),
    .tick_o (tick)
  );

  mgb_frame_seq #(.DATA_W(DATA_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .data_i      (data_i),
    .adv_i       (sending && tick),
    .active_i    (sending),
    .drive_low_o (drive_low_o),
    .last_o      (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      rate_q <= '0;
      idle_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_set_i) begin
          go_q   <= 1'b1;
          rate_q <= rate_i;
          st_q   <= ST_ARM;
        end
        ST_ARM: begin
          busy_q <= 1'b1;
          st_q   <= ST_SEND;
        end
        ST_SEND: if (tick && last) begin
          idle_q <= '0;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          if (idle_q == IDLE_W'(IDLE_INTS - 1)) begin
            busy_q <= 1'b0;
            go_q   <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            idle_q <= idle_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign go_o   = go_q;

  // R2
  arm_to_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !busy_o) |=> busy_o);
  // R3
  busy_has_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> go_o);
  // R3
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && go_set_i) |=> $stable(rate_q));
  // R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || st_q == ST_HOLD) |-> !drive_low_o);
  // R9
  clear_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $fell(go_o));
endmodule

// File: tb/test_mgb_encoder.sv
`timescale 1ns/1ps
module test_mgb_encoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       go_set_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [1:0] rate_i = '0;
  logic       busy_o, go_o, drive_low_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_en = 1'b0;

  logic [2:0] exp_q[$];   // {drive_low, busy, go}
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  mgb_encoder i_mgb_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_set_i(go_set_i), .data_i(data_i),
    .rate_i(rate_i), .busy_o(busy_o), .go_o(go_o), .drive_low_o(drive_low_o)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t act{dl,busy,go}=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  // reference model: compared every clock, 1 ns after the edge
  always begin
    @(posedge clk_i);
    #1;
    if (chk_en) begin
      if (exp_q.size() != 0) begin
        check(tag_q.pop_front(), {drive_low_o, busy_o, go_o}, exp_q.pop_front());
      end else begin
        check("R9 idle", {drive_low_o, busy_o, go_o}, 3'b000);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_model(logic [7:0] d, logic [1:0] r, bit poke);
    logic [15:0] f = {8'hFE, d};
    int div = 1 << r;
    exp_q.push_back(3'b001); tag_q.push_back("R2 arm");
    for (int h = 0; h < 32; h++) begin
      logic b = f[15 - h/2];
      logic dl = (h % 2 == 0) ? !b : b;
      string t;
      if (poke)            t = "R3 ignored go";
      else if (h < 16)     t = (r != 0) ? "R4 rate" : "R5 sync";
      else if (h < 18)     t = "R6 msb first";
      else if (h >= 30 && d[0]) t = "R10 last one";
      else                 t = "R7 encode";
      for (int k = 0; k < div; k++) begin
        exp_q.push_back({dl, 2'b11}); tag_q.push_back(t);
      end
    end
    for (int k = 0; k < 4 * div; k++) begin
      exp_q.push_back(3'b011); tag_q.push_back("R8 hold idle");
    end
  endtask

  task automatic send(logic [7:0] d, logic [1:0] r, bit poke);
    @(negedge clk_i);
    go_set_i = 1'b1; data_i = d; rate_i = r;
    push_model(d, r, poke);
    @(negedge clk_i);
    if (poke) begin
      data_i = ~d; rate_i = r ^ 2'b01;     // arm cycle: must be ignored
      @(negedge clk_i);
      go_set_i = 1'b0;
      repeat (20) @(negedge clk_i);
      go_set_i = 1'b1; data_i = 8'h00; rate_i = 2'b11; // mid-send
      @(negedge clk_i);
    end
    go_set_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk_i);
      check("R1 reset", {drive_low_o, busy_o, go_o}, 3'b000);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", {drive_low_o, busy_o, go_o}, 3'b000);
    chk_en = 1'b1;
    send(8'h5A, 2'd0, 1'b0);
    send(8'hA5, 2'd1, 1'b0);
    send(8'h00, 2'd2, 1'b0);
    send(8'hFF, 2'd3, 1'b0);
    send(8'h81, 2'd0, 1'b1);
    send(8'h3C, 2'd1, 1'b1);
    send(8'h01, 2'd0, 1'b0);
    repeat (5) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule